// File: doc/BRIEF.md
# Processor ALU with Status Flags

This block is the combinational arithmetic logic unit of a small four-cycle processor. It receives the 4-bit opcode decoded from the instruction register, two 8-bit operands read from the register file, and the two raw 4-bit operand fields of the instruction. It returns an 8-bit result together with a carry flag and an overflow flag. The sequencer latches the result into its working register at the end of the execute cycle. The ALU itself holds no state and has no clock.

Arithmetic opcodes (add, subtract, multiply, divide) work on the register operands and produce flags. Bitwise opcodes and immediate opcodes always return both flags low. The immediate opcodes are load-immediate and jump. They ignore the register operands and place the two instruction fields side by side as an 8-bit value: a constant for a register, or a jump target for the program counter. The halt opcode and the codes with no assigned meaning produce an all-zero output.

Internally the top module decodes the opcode into one of four routes: arithmetic, bitwise, immediate or none. The arithmetic and bitwise datapaths are separate submodules. Their low opcode bits select the operation inside each datapath.

Top module: `alu_core`

## Requirements
- R1: Opcode 4'h0 (add) returns (A+B) mod 256, and carry equals bit 8 of the 9-bit unsigned sum.
- R2: Opcode 4'h1 (subtract) returns (A-B) mod 256, and carry is the borrow, set exactly when A < B unsigned.
- R3: For add, overflow is set when A[7] equals B[7] and the result's bit 7 differs from A[7]. For subtract, overflow is set when A[7] differs from B[7] and the result's bit 7 differs from A[7]. Overflow is 0 for every other opcode.
- R4: Opcode 4'h2 (multiply) returns the low 8 bits of the unsigned product, and carry is set when the product exceeds 255.
- R5: Opcode 4'h3 (divide) returns the unsigned quotient A/B with both flags 0. When B is 0 it returns 8'hFF with both flags 0.
- R6: Opcodes 4'h4 (AND), 4'h5 (OR) and 4'h6 (XOR) apply the operation bitwise to A and B. Opcode 4'h7 (NOT) returns the bitwise inverse of A. All four return both flags 0.
- R7: Opcodes 4'h8 (load immediate) and 4'h9 (jump) return {RA, RB}, with RA as the upper nibble. A and B have no effect, and both flags are 0.
- R8: Opcode 4'hF (halt) and the unassigned codes 4'hA to 4'hE return result 0 with both flags 0, whatever the other inputs are.
- R9: The outputs depend only on the present inputs and settle within the same cycle as an input change, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First register operand |
| b_i | input | 8 | Second register operand |
| ra_i | input | 4 | First instruction field, used as a value by immediate opcodes |
| rb_i | input | 4 | Second instruction field, used as a value by immediate opcodes |
| res_o | output | 8 | Result |
| carry_o | output | 1 | Carry or borrow flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
Each opcode is first driven with directed operands chosen to separate the cases:
- Sums that just reach and just exceed 255 test the carry.
- Equal-sign operands whose sum crosses the sign bit, and mixed-sign operands, test the add overflow.
- Subtractions with A below, equal to and above B test the borrow and the subtract overflow.
- Products that stay under 256 and products that reach it test the multiply carry.
- A zero divisor and a divisor larger than the dividend test the divide corner cases.

For the immediate, halt and unassigned opcodes, A and B are changed while the instruction fields are held constant. This shows that the result follows only the fields, or stays at zero. A long pseudo-random run over all sixteen codes then compares every output against a model built from integer arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int ALU_DATA_W  = 8;
    localparam int ALU_FIELD_W = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_NOT  = 4'h7,
        OP_LDI  = 4'h8,
        OP_JMP  = 4'h9,
        OP_HALT = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        ROUTE_NONE,
        ROUTE_ARITH,
        ROUTE_LOGIC,
        ROUTE_IMM
    } alu_route_e;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 8
) (
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         ovf_o
);
    localparam int PW = 2 * W;

    logic [W:0]    sum_w;
    logic [W:0]    dif_w;
    logic [PW-1:0] prod_w;

    assign sum_w  = {1'b0, a_i} + {1'b0, b_i};
    assign dif_w  = {1'b0, a_i} - {1'b0, b_i};
    assign prod_w = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};

    always_comb begin
        res_o   = '0;
        carry_o = 1'b0;
        ovf_o   = 1'b0;
        unique case (sel_i)
            2'd0: begin
                res_o   = sum_w[W-1:0];
                carry_o = sum_w[W];
                ovf_o   = ~(a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ sum_w[W-1]);
            end
            2'd1: begin
                res_o   = dif_w[W-1:0];
                carry_o = dif_w[W];
                ovf_o   = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ dif_w[W-1]);
            end
            2'd2: begin
                res_o   = prod_w[W-1:0];
                carry_o = |prod_w[PW-1:W];
            end
            2'd3: begin
                res_o = (b_i == '0) ? '1 : (a_i / b_i);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 8
) (
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        res_o = '0;
        unique case (sel_i)
            2'd0:    res_o = a_i & b_i;
            2'd1:    res_o = a_i | b_i;
            2'd2:    res_o = a_i ^ b_i;
            2'd3:    res_o = ~a_i;
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W  = ALU_DATA_W,
    parameter int FIELD_W = ALU_FIELD_W
) (
    input  logic [3:0]         op_i,
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [FIELD_W-1:0] ra_i,
    input  logic [FIELD_W-1:0] rb_i,
    output logic [DATA_W-1:0]  res_o,
    output logic               carry_o,
    output logic               ovf_o
);
    localparam int IMM_W = 2 * FIELD_W;

    alu_route_e        route;
    logic [DATA_W-1:0] ar_res;
    logic              ar_carry;
    logic              ar_ovf;
    logic [DATA_W-1:0] lg_res;
    logic [IMM_W-1:0]  imm_raw;
    logic [DATA_W-1:0] imm_val;

    assign imm_raw = {ra_i, rb_i};
    assign imm_val = DATA_W'(imm_raw);

    always_comb begin
        route = ROUTE_NONE;
        unique case (op_i)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV: route = ROUTE_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_NOT:  route = ROUTE_LOGIC;
            OP_LDI, OP_JMP:                 route = ROUTE_IMM;
            default:                        route = ROUTE_NONE;
        endcase
    end

    alu_arith #(.W(DATA_W)) u_arith (
        .sel_i   (op_i[1:0]),
        .a_i     (a_i),
        .b_i     (b_i),
        .res_o   (ar_res),
        .carry_o (ar_carry),
        .ovf_o   (ar_ovf)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .sel_i (op_i[1:0]),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (lg_res)
    );

    always_comb begin
        res_o   = '0;
        carry_o = 1'b0;
        ovf_o   = 1'b0;
        unique case (route)
            ROUTE_ARITH: begin
                res_o   = ar_res;
                carry_o = ar_carry;
                ovf_o   = ar_ovf;
            end
            ROUTE_LOGIC: res_o = lg_res;
            ROUTE_IMM:   res_o = imm_val;
            ROUTE_NONE:  ;
            default:     ;
        endcase
    end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int DATA_W  = 8,
    parameter int FIELD_W = 4
) (
    input logic [3:0]         op_i,
    input logic [DATA_W-1:0]  a_i,
    input logic [DATA_W-1:0]  b_i,
    input logic [FIELD_W-1:0] ra_i,
    input logic [FIELD_W-1:0] rb_i,
    input logic [DATA_W-1:0]  res_o,
    input logic               carry_o,
    input logic               ovf_o
);
    always_comb begin
        // R1: adding zero leaves A unchanged and raises no flag
        a_r1_add_zero: assert (!(op_i == 4'h0 && b_i == '0) || (res_o == a_i && !carry_o && !ovf_o))
            else $error("a_r1_add_zero");
        // R2: subtracting an equal value gives zero, no borrow, no overflow
        a_r2_sub_self: assert (!(op_i == 4'h1 && a_i == b_i) || (res_o == '0 && !carry_o && !ovf_o))
            else $error("a_r2_sub_self");
        // R3: overflow only on add or subtract
        a_r3_no_overflow: assert (!(op_i > 4'h1) || !ovf_o)
            else $error("a_r3_no_overflow");
        // R4: a zero factor gives a zero product and no carry
        a_r4_mul_zero: assert (!(op_i == 4'h2 && (a_i == '0 || b_i == '0)) || (res_o == '0 && !carry_o))
            else $error("a_r4_mul_zero");
        // R5: zero divisor saturates to all ones
        a_r5_div_zero: assert (!(op_i == 4'h3 && b_i == '0) || (res_o == '1 && !carry_o))
            else $error("a_r5_div_zero");
        // R6 R7 R8: carry only on arithmetic codes
        a_r6_flags_clear: assert (!(op_i > 4'h3) || !carry_o)
            else $error("a_r6_flags_clear");
        // R8: halt and unassigned codes give zero
        a_r8_idle_zero: assert (!(op_i >= 4'hA) || res_o == '0)
            else $error("a_r8_idle_zero");
    end
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .ra_i    (ra_i),
    .rb_i    (rb_i),
    .res_o   (res_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o)
);

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;
    logic       clk = 1'b0;
    logic [3:0] op;
    logic [7:0] a, b;
    logic [3:0] ra, rb;
    logic [7:0] res;
    logic       cy, ov;
    int         n_run  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    always #2.5 clk = ~clk;

    alu_core u0 (
        .op_i(op), .a_i(a), .b_i(b), .ra_i(ra), .rb_i(rb),
        .res_o(res), .carry_o(cy), .ovf_o(ov)
    );

    function automatic string req_of(input int o);
        case (o)
            0: return "R1/R3";
            1: return "R2/R3";
            2: return "R4";
            3: return "R5";
            4, 5, 6, 7: return "R6";
            8, 9: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic model(input int o, input int x, input int y, input int f1, input int f2,
                         output int r, output int c, output int v);
        int t;
        r = 0; c = 0; v = 0;
        case (o)
            0: begin t = x + y; r = t % 256; c = (t > 255);
                     v = ((x >= 128) == (y >= 128)) && ((x >= 128) != (r >= 128)); end
            1: begin t = x - y; r = (t + 256) % 256; c = (x < y);
                     v = ((x >= 128) != (y >= 128)) && ((x >= 128) != (r >= 128)); end
            2: begin t = x * y; r = t % 256; c = (t > 255); end
            3: r = (y == 0) ? 255 : x / y;
            4: r = x & y;
            5: r = x | y;
            6: r = x ^ y;
            7: r = 255 - x;
            8, 9: r = f1 * 16 + f2;
            default: r = 0;
        endcase
    endtask

    task automatic apply(input int o, input int x, input int y, input int f1, input int f2,
                         input string tag);
        int er, ec, ev;
        @(negedge clk);
        op = o[3:0]; a = x[7:0]; b = y[7:0]; ra = f1[3:0]; rb = f2[3:0];
        #1;
        model(o, x, y, f1, f2, er, ec, ev);
        n_run++;
        if (int'(res) != er || int'(cy) != ec || int'(ov) != ev) begin
            n_fail++;
            $display("FAIL %s op=%0h a=%0h b=%0h: got res=%0h c=%0d v=%0d, expected res=%0h c=%0d v=%0d",
                     tag, o, x, y, res, cy, ov, er, ec, ev);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        op = 0; a = 0; b = 0; ra = 0; rb = 0;
        apply(0, 0, 0, 0, 0, "R9 initial zero inputs");
        apply(0, 8'hFF, 1, 0, 0, "R1 carry wrap");
        apply(0, 8'h80, 8'h7F, 0, 0, "R1 no carry at 255");
        apply(0, 8'h7F, 1, 0, 0, "R3 add positive overflow");
        apply(0, 8'h80, 8'h80, 0, 0, "R3 add negative overflow");
        apply(0, 8'h80, 8'h01, 0, 0, "R3 mixed sign no overflow");
        apply(1, 3, 5, 0, 0, "R2 borrow");
        apply(1, 5, 5, 0, 0, "R2 equal");
        apply(1, 8'h80, 1, 0, 0, "R3 sub overflow");
        apply(1, 8'h7F, 8'hFF, 0, 0, "R3 sub overflow pos");
        apply(2, 15, 17, 0, 0, "R4 product 255");
        apply(2, 16, 16, 0, 0, "R4 product 256");
        apply(2, 8'hFF, 8'hFF, 0, 0, "R4 max product");
        apply(3, 200, 7, 0, 0, "R5 quotient");
        apply(3, 3, 9, 0, 0, "R5 divisor larger");
        apply(3, 42, 0, 0, 0, "R5 divide by zero");
        apply(4, 8'hF0, 8'h3C, 0, 0, "R6 and");
        apply(5, 8'hF0, 8'h3C, 0, 0, "R6 or");
        apply(6, 8'hF0, 8'h3C, 0, 0, "R6 xor");
        apply(7, 8'h5A, 8'hFF, 0, 0, "R6 not");
        apply(8, 8'hFF, 8'hFF, 4'hA, 4'h5, "R7 ldi with A B ones");
        apply(8, 0, 0, 4'hA, 4'h5, "R7 ldi with A B zero");
        apply(9, 8'h12, 8'h34, 4'h1, 4'hE, "R7 jmp target");
        apply(15, 8'hFF, 8'hFF, 4'hF, 4'hF, "R8 halt");
        for (int k = 10; k < 15; k++) apply(k, 8'hFF, 8'h01, 4'h7, 4'h3, "R8 unassigned");
        for (int k = 0; k < 600; k++) begin
            int o;
            o = int'($urandom_range(0, 15));
            apply(o, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), req_of(o));
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule